// File: doc/BRIEF.md
# Clock Policy Engine Controller

This block selects which of four operating policies governs a group of clocks and drives one enable per clock from the policy in force. Policies are numbered 0 to 3, where a lower number costs less power. Each policy owns one mask register holding one enable bit per clock. A clock keeps the same bit position in all four masks. Software never edits the live enables directly. It stops the engine, rewrites the masks, and then issues a go command. The go command commits the masks and names the policy to apply.

A go command takes one of two paths. In synchronous mode the requested policy becomes active at once, and the busy indication stays up until the voltage-stable handshake input is seen high. In auto-copy mode the requested policy is held as a target while the supply settles. It is copied into the active slot only when the handshake arrives. Both paths commit the edited masks to the outputs at completion. The control register is always written as a whole word, and only its set bits act.

Register map by word address: 0 to 3 are the policy masks (policy number = address). Address 4 is control. On write, bit 0 is go, bit 1 selects synchronous mode and bits [9:8] give the policy. On read, bit 0 is busy, bit 1 is the current mode, [9:8] is the target policy and [13:12] is the active policy. Address 5 is stop. On write, bit 0 requests a stop. On read, bit 0 is the pending stop request and bit 1 is the stopped state. Other addresses read as zero.

Top module: `clk_policy_ctrl`

## Requirements
- R1: After reset the active and target policies are 2, busy reads 0, stop reads 0 and every clock enable is 1 (all masks reset to ones).
- R2: Masks read back at addresses 0 to 3; a mask write is accepted only while the stopped bit (address 5 bit 1) is 1 and is otherwise ignored.
- R3: Mask edits do not reach the clock enable outputs until the next completed go operation.
- R4: After a go completes, the enable outputs equal the committed mask of the active policy.
- R5: A go write sets busy (control bit 0) on its write edge; busy clears on the first later edge at which the voltage-stable input is high.
- R6: A synchronous go (bits 0 and 1 set) makes the active policy (control [13:12]) equal the requested policy on the write edge.
- R7: An auto-copy go (bit 0 set, bit 1 clear) leaves the active policy unchanged while busy and sets it to the target at completion.
- R8: A go write while busy is ignored: target, mode and active policy are unchanged.
- R9: Writing 1 to stop bit 0 makes it read 1; it clears and the stopped bit sets at the first edge at which the engine is not busy; an accepted go clears the stopped bit.
- R10: A control write with bit 0 clear changes neither target, mode, active policy nor busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| volt_stable | input | 1 | Supply-settled handshake |
| clk_en | output | NCLK | Per-clock enables of the active policy |

## Verification
The assertions check, on every cycle, the following rules. Busy falls on the first settled edge. The active policy holds while an auto-copy update waits and jumps on a synchronous go. The enables move only on an accepted go or a completion. A go or a mask write arriving at the wrong time leaves state untouched. The bench scenarios show the values themselves. These include the enables matching the committed mask of the chosen policy, the read-back of masks and fields, and the stop request resolving late when it is raised during an update. Random rounds with random masks, policies, modes and settle delays exercise these values further.

// File: rtl/clk_policy_ctrl.sv
module clk_policy_ctrl #(
  parameter int NCLK = 32,
  parameter logic [1:0] RST_POL = 2'd2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            volt_stable,
  output logic [NCLK-1:0] clk_en
);
  localparam logic [2:0] A_CTRL = 3'd4;
  localparam logic [2:0] A_STOP = 3'd5;
  localparam int POL_LSB = 8;
  localparam int ACT_LSB = 12;

  logic [3:0][NCLK-1:0] mask_q, shadow_q;
  logic [1:0] act_q, tgt_q;
  logic busy_q, sync_q, stop_req_q, stopped_q;

  wire go_wr   = reg_we && reg_addr == A_CTRL && reg_wdata[0];
  wire go_acc  = go_wr && !busy_q;
  wire done    = busy_q && volt_stable;
  wire stop_wr = reg_we && reg_addr == A_STOP && reg_wdata[0];
  wire mask_wr = reg_we && !reg_addr[2] && stopped_q;
  wire [1:0] req_pol = reg_wdata[POL_LSB+1:POL_LSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '1;
      shadow_q   <= '1;
      act_q      <= RST_POL;
      tgt_q      <= RST_POL;
      busy_q     <= 1'b0;
      sync_q     <= 1'b0;
      stop_req_q <= 1'b0;
      stopped_q  <= 1'b0;
    end else begin
      if (stop_wr) stop_req_q <= 1'b1;
      else if (stop_req_q && !busy_q) begin
        stop_req_q <= 1'b0;
        stopped_q  <= 1'b1;
      end
      if (mask_wr) mask_q[reg_addr[1:0]] <= reg_wdata[NCLK-1:0];
      if (go_acc) begin
        busy_q    <= 1'b1;
        sync_q    <= reg_wdata[1];
        tgt_q     <= req_pol;
        stopped_q <= 1'b0;
        if (reg_wdata[1]) act_q <= req_pol;
      end else if (done) begin
        busy_q   <= 1'b0;
        shadow_q <= mask_q;
        if (!sync_q) act_q <= tgt_q;
      end
    end
  end

  assign clk_en = shadow_q[act_q];

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[2]) reg_rdata[NCLK-1:0] = mask_q[reg_addr[1:0]];
    else if (reg_addr == A_CTRL) begin
      reg_rdata[0] = busy_q;
      reg_rdata[1] = sync_q;
      reg_rdata[POL_LSB+1:POL_LSB] = tgt_q;
      reg_rdata[ACT_LSB+1:ACT_LSB] = act_q;
    end else if (reg_addr == A_STOP) reg_rdata[1:0] = {stopped_q, stop_req_q};
  end

  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R5
  AST_SYNC_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    go_acc && reg_wdata[1] |=> act_q == $past(req_pol)); // R6
  AST_ASYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !sync_q && !volt_stable |=> $stable(act_q)); // R7
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && go_wr |=> $stable(tgt_q) && $stable(sync_q)); // R8
  AST_EN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !go_acc |=> $stable(clk_en)); // R3
  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped_q |=> $stable(mask_q)); // R2
endmodule

// File: tb/clk_policy_ctrl_tb_top.sv
module clk_policy_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, volt_stable = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, clk_en;
  int n_chk = 0, n_fail = 0;
  logic [31:0] mdl [4];
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  clk_policy_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .volt_stable(volt_stable), .clk_en(clk_en));

  function automatic logic [31:0] go_word(input logic [1:0] pol, input logic sync);
    return 32'h1 | (32'(sync) << 1) | (32'(pol) << 8);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask
  task automatic settle();
    @(negedge clk); volt_stable = 1'b1;
    @(negedge clk); volt_stable = 1'b0;
  endtask
  task automatic do_stop();
    wr(3'd5, 32'h1); tick();
  endtask

  initial begin
    #500000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) mdl[i] = '1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(3'd4, rv); chk("R1 ctrl", rv, 32'h0000_2200);
    rd(3'd5, rv); chk("R1 stop", rv, 32'h0);
    chk("R1 clk_en", clk_en, 32'hffff_ffff);
    // R2 mask write ignored while running
    wr(3'd0, 32'h1234_5678);
    rd(3'd0, rv); chk("R2 locked", rv, 32'hffff_ffff);
    // R9 stop from idle
    wr(3'd5, 32'h1);
    rd(3'd5, rv); chk("R9 pending", rv, 32'h1);
    tick();
    rd(3'd5, rv); chk("R9 stopped", rv, 32'h2);
    // R2 mask edits, R3 no effect yet
    for (int i = 0; i < 4; i++) begin
      mdl[i] = $urandom;
      wr(3'(i), mdl[i]);
    end
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), rv); chk("R2 readback", rv, mdl[i]);
    end
    chk("R3 not committed", clk_en, 32'hffff_ffff);
    // R10 control write without go
    wr(3'd4, 32'h0000_0002);
    rd(3'd4, rv); chk("R10 no go", rv, 32'h0000_2200);
    // R7 auto-copy go to policy 1
    wr(3'd4, go_word(2'd1, 1'b0));
    rd(3'd4, rv); chk("R5 R7 busy", rv, 32'h0000_2101);
    rd(3'd5, rv); chk("R9 go restarts", rv, 32'h0);
    repeat (3) tick();
    rd(3'd4, rv); chk("R7 held", rv[13:12], 32'd2);
    // R8 go while busy
    wr(3'd4, go_word(2'd3, 1'b1));
    rd(3'd4, rv); chk("R8 ignored", rv, 32'h0000_2101);
    chk("R3 still old", clk_en, 32'hffff_ffff);
    settle();
    rd(3'd4, rv); chk("R5 R7 done", rv, 32'h0000_1100);
    chk("R4 en", clk_en, mdl[1]);
    // R6 sync go to policy 0 after mask edit, stop raised during update
    do_stop();
    mdl[0] = ~mdl[0];
    wr(3'd0, mdl[0]);
    wr(3'd4, go_word(2'd0, 1'b1));
    rd(3'd4, rv); chk("R6 switch", rv, 32'h0000_0003);
    chk("R3 sync old mask", clk_en, ~mdl[0]);
    wr(3'd5, 32'h1);
    tick();
    rd(3'd5, rv); chk("R9 pending busy", rv, 32'h1);
    settle();
    rd(3'd4, rv); chk("R5 sync done", rv[0], 32'h0);
    chk("R4 sync en", clk_en, mdl[0]);
    tick();
    rd(3'd5, rv); chk("R9 late stop", rv, 32'h2);
    // random rounds
    for (int k = 0; k < 24; k++) begin
      logic [1:0] pol;
      logic sync;
      int d;
      do_stop();
      for (int i = 0; i < 4; i++) if ($urandom_range(1, 0) == 1) begin
        mdl[i] = $urandom;
        wr(3'(i), mdl[i]);
      end
      pol = 2'($urandom_range(3, 0));
      sync = 1'($urandom_range(1, 0));
      wr(3'd4, go_word(pol, sync));
      d = $urandom_range(3, 0);
      repeat (d) tick();
      rd(3'd4, rv); chk("R5 rnd busy", rv[0], 32'h1);
      settle();
      rd(3'd4, rv); chk("R6 R7 rnd act", 32'(rv[13:12]), 32'(pol));
      chk("R4 rnd en", clk_en, mdl[pol]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule